// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address with 64-byte pages. A 16-entry translation cache, arranged as 4 sets of 4 ways, holds recent page mappings. The cache is indexed and tagged only on the virtual page number. The low six offset bits never take part in the lookup and are copied straight into the physical address.

When the lookup misses, the unit reads a single-level page table of 256 entries through a one-cycle-latency read port on its own. A valid entry is installed in the indexed set and returned as the translation. An invalid entry is reported as a page fault with no address. While a page table read is in flight, a busy output tells the requester that new requests are not taken. A flush input empties the whole cache in one cycle.

Top module: `xlate_unit`

## Requirements
- R1: After reset, resp_valid, busy and pt_rd_en are low and the cache holds no valid entry, so the first lookup of any page misses.
- R2: A translated physical address is the 6-bit physical page number in bits 11:6, concatenated with virtual address bits 5:0 copied unchanged into bits 5:0.
- R3: The set is virtual page number bits 1:0 and the tag is virtual page number bits 7:2 (virtual address bits 13:8). A request whose tag matches a valid way of its set is answered in the cycle right after the accepting edge, with resp_hit=1 and resp_fault=0, and starts no page table read.
- R4: On a miss, pt_rd_en is high for exactly one cycle right after the accepting edge, with pt_rd_addr equal to the full virtual page number. busy is high until the response, and the response appears two cycles after the read cycle.
- R5: Page table data is 7 bits: bit 6 is the valid flag and bits 5:0 are the physical page number. A valid entry answers with resp_hit=0 and resp_fault=0, and is installed so that the next request to that page hits.
- R6: An entry with bit 6 clear answers with resp_fault=1, resp_hit=0 and resp_paddr=0. It is not installed, so a repeat request misses again.
- R7: A refill goes to the lowest-numbered invalid way of the set. If all four ways are valid, it goes to the way named by that set's round-robin pointer, which starts at way 0 and advances by one, wrapping, after each such replacement. Other sets are untouched.
- R8: flush clears every valid bit and returns every round-robin pointer to way 0 in one cycle, so a page that hit before the flush misses after it.
- R9: A request presented while busy is high is ignored: it causes no response and no page table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address of the request |
| busy | output | 1 | A miss is being served; requests are not taken |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from the cache |
| resp_fault | output | 1 | Page table entry was invalid |
| resp_paddr | output | 12 | Physical address (0 on a fault) |
| pt_rd_en | output | 1 | Page table read strobe |
| pt_rd_addr | output | 8 | Page table index (virtual page number) |
| pt_rd_data | input | 7 | Page table entry, returned one cycle after pt_rd_en |

## Verification
The assertions take for granted that the page table answers exactly one cycle after pt_rd_en. They also assume that req_vaddr at the accepting edge is the address whose offset the hit response must carry, and that flush does not coincide with a refill. The bench models the table as a registered read of entries computed arithmetically. It drives every input at the falling edge and asserts flush only while the unit is idle. The one stray request it sends is presented only while busy is high, to check that it is ignored.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_RESP = 2'd2
  } xl_state_e;
endpackage

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  row_valid,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way,
  output logic             has_free
);
  always_comb begin
    way      = rr_ptr;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_valid[w]) begin
        way      = WAY_W'(w);
        has_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlate_tcache.sv
module xlate_tcache #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];

  logic [WAYS-1:0]  match_vec;
  logic [WAY_W-1:0] vic_way;
  logic             vic_free;
  logic             any_vld;

  always_comb begin
    match_vec = '0;
    lk_ppn    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag)) begin
        match_vec[w] = 1'b1;
        lk_ppn       = lk_ppn | ppn_q[lk_idx][w];
      end
    end
    lk_hit = |match_vec;
  end

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  xlate_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .row_valid (vld_q[wr_idx]),
    .rr_ptr    (ptr_q[wr_idx]),
    .way       (vic_way),
    .has_free  (vic_free)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx][vic_way] <= 1'b1;
      if (!vic_free) begin
        ptr_q[wr_idx] <= (ptr_q[wr_idx] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[wr_idx] + 1'b1;
      end
    end
  end

  // Tag and page storage carry no reset, as in a RAM.
  always_ff @(posedge clk) begin
    if (wr_en && !flush && !rst) begin
      tag_q[wr_idx][vic_way] <= wr_tag;
      ppn_q[wr_idx][vic_way] <= wr_ppn;
    end
  end

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !any_vld);

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> !any_vld);
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int OFF_W = 6,
  parameter int IDX_W = 2,
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int VA_W  = VPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             hit_in,
  input  logic [PPN_W-1:0] hit_ppn,
  output logic             busy,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             pt_rd_en,
  output logic [VPN_W-1:0] pt_rd_addr,
  input  logic [PPN_W:0]   pt_rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PPN_W-1:0] wr_ppn
);
  xl_state_e        state_q;
  logic [OFF_W-1:0] off_q;
  logic             pte_ok;

  assign pte_ok = pt_rd_data[PPN_W];
  assign busy   = (state_q != ST_IDLE);
  assign wr_en  = (state_q == ST_RESP) && pte_ok;
  assign wr_idx = pt_rd_addr[IDX_W-1:0];
  assign wr_tag = pt_rd_addr[VPN_W-1:IDX_W];
  assign wr_ppn = pt_rd_data[PPN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      pt_rd_en   <= 1'b0;
      pt_rd_addr <= '0;
    end else begin
      resp_valid <= 1'b0;
      pt_rd_en   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (hit_in) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              resp_fault <= 1'b0;
              resp_paddr <= {hit_ppn, req_vaddr[OFF_W-1:0]};
            end else begin
              state_q    <= ST_READ;
              pt_rd_en   <= 1'b1;
              pt_rd_addr <= req_vaddr[VA_W-1:OFF_W];
              off_q      <= req_vaddr[OFF_W-1:0];
            end
          end
        end
        ST_READ: state_q <= ST_RESP;
        ST_RESP: begin
          state_q    <= ST_IDLE;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_fault <= !pte_ok;
          resp_paddr <= pte_ok ? {pt_rd_data[PPN_W-1:0], off_q} : '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R4
  miss_reads_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> pt_rd_en);

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    pt_rd_en |=> !pt_rd_en);

  // R6
  fault_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (!resp_hit && resp_paddr == '0));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !resp_valid);
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int VA_W = 14,
  parameter int PA_W = 12,
  parameter int OFF_W = 6,
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W = VPN_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             busy,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             pt_rd_en,
  output logic [VPN_W-1:0] pt_rd_addr,
  input  logic [PPN_W:0]   pt_rd_data
);
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [PPN_W-1:0] wr_ppn;

  xlate_tcache #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_cache (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .lk_idx (req_vaddr[OFF_W+IDX_W-1:OFF_W]),
    .lk_tag (req_vaddr[VA_W-1:OFF_W+IDX_W]),
    .lk_hit (lk_hit),
    .lk_ppn (lk_ppn),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_tag (wr_tag),
    .wr_ppn (wr_ppn)
  );

  xlate_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .hit_in     (lk_hit),
    .hit_ppn    (lk_ppn),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .pt_rd_en   (pt_rd_en),
    .pt_rd_addr (pt_rd_addr),
    .pt_rd_data (pt_rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_tag     (wr_tag),
    .wr_ppn     (wr_ppn)
  );
endmodule

// File: tb/tb_xlate_unit.sv
module tb_xlate_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        busy, resp_valid, resp_hit, resp_fault, pt_rd_en;
  logic [11:0] resp_paddr;
  logic [7:0]  pt_rd_addr;
  logic [6:0]  pt_rd_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlate_unit dut (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr),
    .pt_rd_data(pt_rd_data)
  );

  function automatic bit pte_ok(input logic [7:0] vpn);
    return (vpn % 5) != 3;
  endfunction
  function automatic logic [5:0] pte_ppn(input logic [7:0] vpn);
    return 6'((int'(vpn) * 7 + 3) % 64);
  endfunction

  always @(posedge clk) if (pt_rd_en) pt_rd_data <= {pte_ok(pt_rd_addr), pte_ppn(pt_rd_addr)};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic       r_hit, r_fault;
  logic [11:0] r_paddr;
  int          r_lat, r_reads;
  logic [7:0]  r_rdaddr;

  task automatic do_req(input logic [13:0] va, input bit stray, input logic [13:0] stray_va);
    bit got = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    r_lat = 0; r_reads = 0; r_rdaddr = '0;
    for (int c = 0; c < 20 && !got; c++) begin
      @(negedge clk);
      r_lat++;
      if (stray && busy) begin
        req_valid = 1'b1; req_vaddr = stray_va;
      end else begin
        req_valid = 1'b0;
      end
      if (pt_rd_en) begin r_reads++; r_rdaddr = pt_rd_addr; end
      if (resp_valid) begin
        got = 1; r_hit = resp_hit; r_fault = resp_fault; r_paddr = resp_paddr;
        req_valid = 1'b0;
      end
    end
    if (!got) check(0, "R4 response timeout", 0, 1);
  endtask

  task automatic expect_hit(input logic [7:0] vpn, input logic [5:0] off, input string tag);
    do_req({vpn, off}, 0, '0);
    check(r_hit == 1 && r_fault == 0, tag, r_hit, 1);
    check(r_lat == 1 && r_reads == 0, {tag, " hit latency"}, r_lat, 1);
    check(r_paddr == {pte_ppn(vpn), off}, {tag, " paddr"}, r_paddr, {pte_ppn(vpn), off});
  endtask

  task automatic expect_miss(input logic [7:0] vpn, input logic [5:0] off, input string tag);
    do_req({vpn, off}, 0, '0);
    check(r_hit == 0 && r_lat == 3 && r_reads == 1, tag, {r_hit, 8'(r_lat)}, 3);
    check(r_rdaddr == vpn, {tag, " R4 read addr"}, r_rdaddr, vpn);
    if (pte_ok(vpn)) check(r_fault == 0 && r_paddr == {pte_ppn(vpn), off}, {tag, " R5 R2"},
                           r_paddr, {pte_ppn(vpn), off});
    else check(r_fault == 1 && r_paddr == 0, {tag, " R6 fault"}, {r_fault, r_paddr}, 13'h1000);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check(resp_valid == 0 && busy == 0 && pt_rd_en == 0, "R1 reset outputs",
          {resp_valid, busy, pt_rd_en}, 0);
    expect_miss(8'h00, 6'h15, "R1 first lookup misses");

    // R3 R5 R6 R2: sweep every page, twice each
    for (int v = 1; v < 256; v++) begin
      logic [5:0] off = 6'((v * 3 + 1) % 64);
      expect_miss(8'(v), off, "R4 sweep first");
      if (pte_ok(8'(v))) expect_hit(8'(v), 6'(63 - off), "R3 sweep repeat");
      else expect_miss(8'(v), off, "R6 sweep not installed");
    end

    // R8 flush
    expect_hit(8'd255, 6'h2a, "R3 before flush");
    do_flush();
    expect_miss(8'd255, 6'h2a, "R8 after flush");
    expect_hit(8'd255, 6'h01, "R8 refill after flush");

    // R7 replacement in set 1 (A=1 B=5 C=9 D=17 E=21), set 2 isolation (X=2)
    do_flush();
    expect_miss(8'd1, 6'h0, "R7 fill A");
    expect_miss(8'd5, 6'h0, "R7 fill B");
    expect_miss(8'd9, 6'h0, "R7 fill C");
    expect_miss(8'd17, 6'h0, "R7 fill D");
    expect_miss(8'd2, 6'h0, "R7 fill X");
    expect_hit(8'd1, 6'h3f, "R7 A held");
    expect_hit(8'd5, 6'h3f, "R7 B held");
    expect_hit(8'd9, 6'h3f, "R7 C held");
    expect_hit(8'd17, 6'h3f, "R7 D held");
    expect_miss(8'd21, 6'h0, "R7 E replaces way0");
    expect_hit(8'd5, 6'h1, "R7 B survives");
    expect_hit(8'd9, 6'h1, "R7 C survives");
    expect_hit(8'd17, 6'h1, "R7 D survives");
    expect_hit(8'd21, 6'h1, "R7 E present");
    expect_miss(8'd1, 6'h0, "R7 A evicted");
    expect_miss(8'd5, 6'h0, "R7 B evicted by A");
    expect_hit(8'd17, 6'h2, "R7 D still");
    expect_hit(8'd21, 6'h2, "R7 E still");
    expect_hit(8'd1, 6'h2, "R7 A back");
    expect_hit(8'd5, 6'h2, "R7 B back");
    expect_miss(8'd9, 6'h0, "R7 C evicted by B");
    expect_hit(8'd2, 6'h3, "R7 other set untouched");

    // R9 stray request while busy
    do_req({8'd25, 6'h11}, 1, {8'd33, 6'h04});
    check(r_reads == 1 && r_lat == 3, "R9 single read", r_reads, 1);
    begin
      int extra = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (resp_valid || pt_rd_en) extra++;
      end
      check(extra == 0, "R9 no extra activity", extra, 0);
    end
    expect_miss(8'd33, 6'h04, "R9 stray not served");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule